// File: doc/BRIEF.md
# NVM Command Sequencer with Low-Power and Debug Handling

This block sequences commands for a small on-chip non-volatile memory. Software places one command in a single-entry holding slot; the sequencer takes it from the slot, starts the array operation and waits for its completion. The slot can be refilled as soon as it has been taken, so a second command can wait while the first runs. Three flags are reported: slot empty, all work complete, and access error. An interrupt request is formed from the first two under separate enables.

The block reacts to the chip's power states. A wait request changes nothing about the work in progress: both the running and the waiting command finish. A stop request kills a running operation, cuts the high-voltage enable in the same cycle, marks the access error, and throws away any waiting command when stop is released. A security input combined with the special single-chip input narrows the accepted commands to mass erase. A small protection register can be written once in normal operation and freely while debug is active. The array and its charge pump are modelled as a start pulse followed, after a programmable number of cycles, by a done pulse.

Top module: `nvm_cmd_ctrl`

## Requirements
- R1: A command write is accepted when the slot is empty, the access error is clear, stop is low and the opcode is allowed; then `buf_empty` and `cmd_done` both read 0 from the next cycle. Opcodes: 0 verify, 1 program, 2 sector erase, 3 mass erase, 4 sector modify.
- R2: With latency L (L=0 acts as 1), `cmd_done` goes high L+2 cycles after the accepting edge; a second command accepted while the first runs extends the low time to 2L+4 cycles.
- R3: `pump_en` is high only while a command with opcode 1 to 4 is executing; it stays low while opcode 0 executes.
- R4: A high `wait_req` has no effect on a running or waiting command; both complete with the R2 timing.
- R5: `irq` is (`ie_buf_empty` and `buf_empty`) or (`ie_cmd_done` and `cmd_done`); `wake_req` is `irq` gated by `wait_req`.
- R6: Stop raised during launch or execution aborts the command: one cycle later `acc_err` and `cmd_done` both read 1.
- R7: `pump_en` reads 0 in any cycle in which `stop_req` is high.
- R8: When stop falls, `buf_empty` reads 1 the next cycle and a waiting command is discarded, never started.
- R9: While `acc_err` is 1, command writes are refused and leave the slot empty; a pulse on `acc_err_clr` clears the flag.
- R10: A write with opcode 5, 6 or 7, or a write while the slot is occupied, sets `acc_err` and leaves the slot contents unchanged.
- R11: With `sec_on` and `spec_single` both high, only opcode 3 is accepted; any other opcode sets `acc_err`.
- R12: `prot_q` takes a write while `dbg_mode` is high at any time; with `dbg_mode` low it takes only the first write after reset.
- R13: After reset `buf_empty`=1, `cmd_done`=1, `acc_err`=0, `pump_en`=0 and `prot_q`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_wr | input | 1 | Command write strobe |
| cmd_op | input | 3 | Command opcode |
| acc_err_clr | input | 1 | Clears the access error flag |
| lat | input | LAT_W | Array operation latency in cycles |
| stop_req | input | 1 | Stop mode request (level) |
| wait_req | input | 1 | Wait mode request (level) |
| dbg_mode | input | 1 | Debug mode active |
| sec_on | input | 1 | Chip is secured |
| spec_single | input | 1 | Special single-chip operating mode |
| ie_buf_empty | input | 1 | Interrupt enable for slot empty |
| ie_cmd_done | input | 1 | Interrupt enable for work complete |
| prot_wr | input | 1 | Protection register write strobe |
| prot_data | input | PROT_W | Protection register write data |
| buf_empty | output | 1 | Command slot is empty |
| cmd_done | output | 1 | No command running or waiting |
| acc_err | output | 1 | Access error flag |
| pump_en | output | 1 | High-voltage pump enable |
| irq | output | 1 | Interrupt request |
| wake_req | output | 1 | Wake-up request out of wait mode |
| prot_q | output | PROT_W | Protection register value |

## Verification
A wrong sequencer state shows at the ports within one cycle: a missed abort leaves `acc_err` low and `cmd_done` low the cycle after stop rises, and a stale slot after stop release either keeps `buf_empty` low or later drops `cmd_done` for a command that should never run. Timing faults in the launch or execution path appear as a `cmd_done` low window that differs from L+2 or 2L+4 cycles, which the scoreboard measures per completion. Pump faults appear in the same cycle as the stop request or during a verify command.

// File: rtl/nvm_cmd_pkg.sv
package nvm_cmd_pkg;

    localparam int OP_W = 3;

    typedef enum logic [OP_W-1:0] {
        OP_VERIFY     = 3'd0,
        OP_PROGRAM    = 3'd1,
        OP_SEC_ERASE  = 3'd2,
        OP_MASS_ERASE = 3'd3,
        OP_SEC_MODIFY = 3'd4
    } nvm_op_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LAUNCH = 2'd1,
        ST_EXEC   = 2'd2,
        ST_ABORT  = 2'd3
    } ctl_state_e;

    function automatic logic op_legal(input logic [OP_W-1:0] op);
        return op <= OP_SEC_MODIFY;
    endfunction

    function automatic logic op_high_voltage(input logic [OP_W-1:0] op);
        return (op != OP_VERIFY) && op_legal(op);
    endfunction

    function automatic logic op_permitted(input logic [OP_W-1:0] op,
                                          input logic restricted);
        return op_legal(op) && (!restricted || op == OP_MASS_ERASE);
    endfunction

endpackage

// File: rtl/nvm_cmd_gate.sv
module nvm_cmd_gate
    import nvm_cmd_pkg::*;
(
    input  logic [OP_W-1:0] op,
    input  logic            sec_on,
    input  logic            spec_single,
    output logic            ok
);
    logic restricted;

    always_comb begin
        restricted = sec_on & spec_single;
        ok         = op_permitted(op, restricted);
    end
endmodule

// File: rtl/nvm_cmd_buf.sv
module nvm_cmd_buf
    import nvm_cmd_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            load,
    input  logic [OP_W-1:0] op_in,
    input  logic            pop,
    input  logic            flush,
    output logic            full,
    output logic [OP_W-1:0] op_out
);
    always_ff @(posedge clk) begin
        if (rst) begin
            full   <= 1'b0;
            op_out <= '0;
        end else if (flush || pop) begin
            full   <= 1'b0;
        end else if (load) begin
            full   <= 1'b1;
            op_out <= op_in;
        end
    end
endmodule

// File: rtl/nvm_array_model.sv
module nvm_array_model #(
    parameter int LAT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             cancel,
    input  logic [LAT_W-1:0] lat,
    output logic             done
);
    localparam logic [LAT_W-1:0] ONE = LAT_W'(1);

    logic             busy_q;
    logic [LAT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || cancel) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (start) begin
            busy_q <= 1'b1;
            cnt_q  <= (lat == '0) ? ONE : lat;
        end else if (busy_q) begin
            if (cnt_q == ONE) busy_q <= 1'b0;
            else              cnt_q  <= cnt_q - ONE;
        end
    end

    assign done = busy_q && (cnt_q == ONE);
endmodule

// File: rtl/nvm_prot_reg.sv
module nvm_prot_reg #(
    parameter int PROT_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [PROT_W-1:0] data,
    input  logic              dbg_mode,
    output logic [PROT_W-1:0] q
);
    logic locked_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            q        <= '0;
            locked_q <= 1'b0;
        end else if (wr && (dbg_mode || !locked_q)) begin
            q <= data;
            if (!dbg_mode) locked_q <= 1'b1;
        end
    end
endmodule

// File: rtl/nvm_cmd_ctrl.sv
module nvm_cmd_ctrl
    import nvm_cmd_pkg::*;
#(
    parameter int LAT_W  = 8,
    parameter int PROT_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_wr,
    input  logic [2:0]        cmd_op,
    input  logic              acc_err_clr,
    input  logic [LAT_W-1:0]  lat,
    input  logic              stop_req,
    input  logic              wait_req,
    input  logic              dbg_mode,
    input  logic              sec_on,
    input  logic              spec_single,
    input  logic              ie_buf_empty,
    input  logic              ie_cmd_done,
    input  logic              prot_wr,
    input  logic [PROT_W-1:0] prot_data,
    output logic              buf_empty,
    output logic              cmd_done,
    output logic              acc_err,
    output logic              pump_en,
    output logic              irq,
    output logic              wake_req,
    output logic [PROT_W-1:0] prot_q
);
    ctl_state_e      state_q, state_d;
    logic            hv_q;
    logic            acc_err_q;
    logic            buf_full;
    logic [OP_W-1:0] buf_op;
    logic            gate_ok;
    logic            arr_done;
    logic            wr_seen, wr_ok, wr_err;
    logic            pop, flush, abort_hit, start;

    nvm_cmd_gate gate_i (
        .op(cmd_op), .sec_on(sec_on), .spec_single(spec_single), .ok(gate_ok)
    );

    nvm_cmd_buf buf_i (
        .clk(clk), .rst(rst), .load(wr_ok), .op_in(cmd_op),
        .pop(pop), .flush(flush), .full(buf_full), .op_out(buf_op)
    );

    nvm_array_model #(.LAT_W(LAT_W)) arr_i (
        .clk(clk), .rst(rst), .start(start), .cancel(stop_req),
        .lat(lat), .done(arr_done)
    );

    nvm_prot_reg #(.PROT_W(PROT_W)) prot_i (
        .clk(clk), .rst(rst), .wr(prot_wr), .data(prot_data),
        .dbg_mode(dbg_mode), .q(prot_q)
    );

    always_comb begin
        wr_seen   = cmd_wr && !stop_req && !acc_err_q;
        wr_ok     = wr_seen && !buf_full && gate_ok;
        wr_err    = wr_seen && (buf_full || !gate_ok);
        pop       = (state_q == ST_IDLE) && buf_full && !stop_req;
        flush     = (state_q == ST_ABORT) && !stop_req;
        abort_hit = stop_req && (state_q == ST_LAUNCH || state_q == ST_EXEC);
        start     = (state_q == ST_LAUNCH) && !stop_req;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (stop_req) state_d = ST_ABORT;
                       else if (pop) state_d = ST_LAUNCH;
            ST_LAUNCH: state_d = stop_req ? ST_ABORT : ST_EXEC;
            ST_EXEC:   if (stop_req) state_d = ST_ABORT;
                       else if (arr_done) state_d = ST_IDLE;
            ST_ABORT:  if (!stop_req) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            hv_q      <= 1'b0;
            acc_err_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (pop) hv_q <= op_high_voltage(buf_op);
            if (wr_err || abort_hit) acc_err_q <= 1'b1;
            else if (acc_err_clr)    acc_err_q <= 1'b0;
        end
    end

    always_comb begin
        buf_empty = !buf_full;
        acc_err   = acc_err_q;
        cmd_done  = (state_q == ST_ABORT) || (state_q == ST_IDLE && !buf_full);
        pump_en   = (state_q == ST_EXEC) && hv_q && !stop_req;
        irq       = (ie_buf_empty && buf_empty) || (ie_cmd_done && cmd_done);
        wake_req  = wait_req && irq;
    end
endmodule

module nvm_cmd_ctrl_chk
    import nvm_cmd_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       stop_req,
    input logic       wait_req,
    input logic       cmd_wr,
    input logic       pump_en,
    input logic       acc_err,
    input logic       cmd_done,
    input logic       buf_empty,
    input logic       wake_req,
    input ctl_state_e state
);
    p_pump_cut_r7: assert property (@(posedge clk) disable iff (rst)
        stop_req |-> !pump_en);

    p_pump_exec_r3: assert property (@(posedge clk) disable iff (rst)
        pump_en |-> (state == ST_EXEC));

    p_busy_not_done_r2: assert property (@(posedge clk) disable iff (rst)
        (state == ST_EXEC || state == ST_LAUNCH) |-> !cmd_done);

    p_abort_flags_r6: assert property (@(posedge clk) disable iff (rst)
        (stop_req && (state == ST_LAUNCH || state == ST_EXEC)) |=> (acc_err && cmd_done));

    p_exit_flush_r8: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ABORT && !stop_req) |=> (buf_empty && cmd_done));

    p_refuse_r9: assert property (@(posedge clk) disable iff (rst)
        (acc_err && cmd_wr && buf_empty && !stop_req) |=> buf_empty);

    p_wake_r5: assert property (@(posedge clk) disable iff (rst)
        wake_req |-> wait_req);
endmodule

bind nvm_cmd_ctrl nvm_cmd_ctrl_chk chk_i (
    .clk(clk), .rst(rst), .stop_req(stop_req), .wait_req(wait_req),
    .cmd_wr(cmd_wr), .pump_en(pump_en), .acc_err(acc_err),
    .cmd_done(cmd_done), .buf_empty(buf_empty), .wake_req(wake_req),
    .state(state_q)
);

// File: tb/nvm_cmd_ctrl_tb.sv
`timescale 1ns/1ps
module nvm_cmd_ctrl_tb_top;
    localparam int LAT_W  = 8;
    localparam int PROT_W = 8;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cmd_wr = 1'b0;
    logic [2:0]        cmd_op = '0;
    logic              acc_err_clr = 1'b0;
    logic [LAT_W-1:0]  lat = 8'd3;
    logic              stop_req = 1'b0;
    logic              wait_req = 1'b0;
    logic              dbg_mode = 1'b0;
    logic              sec_on = 1'b0;
    logic              spec_single = 1'b0;
    logic              ie_buf_empty = 1'b0;
    logic              ie_cmd_done = 1'b0;
    logic              prot_wr = 1'b0;
    logic [PROT_W-1:0] prot_data = '0;
    logic              buf_empty, cmd_done, acc_err, pump_en, irq, wake_req;
    logic [PROT_W-1:0] prot_q;

    int n_chk = 0;
    int n_bad = 0;
    int low_cnt = 0;
    bit finished = 0;
    int exp_dur[$];
    bit exp_err[$];

    always #10 clk = ~clk;

    nvm_cmd_ctrl #(.LAT_W(LAT_W), .PROT_W(PROT_W)) dut_i (
        .clk(clk), .rst(rst), .cmd_wr(cmd_wr), .cmd_op(cmd_op),
        .acc_err_clr(acc_err_clr), .lat(lat), .stop_req(stop_req),
        .wait_req(wait_req), .dbg_mode(dbg_mode), .sec_on(sec_on),
        .spec_single(spec_single), .ie_buf_empty(ie_buf_empty),
        .ie_cmd_done(ie_cmd_done), .prot_wr(prot_wr), .prot_data(prot_data),
        .buf_empty(buf_empty), .cmd_done(cmd_done), .acc_err(acc_err),
        .pump_en(pump_en), .irq(irq), .wake_req(wake_req), .prot_q(prot_q)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic expect_done(input int dur, input bit err);
        exp_dur.push_back(dur);
        exp_err.push_back(err);
    endtask

    task automatic issue(input logic [2:0] op);
        cmd_op = op;
        cmd_wr = 1'b1;
        @(negedge clk);
        cmd_wr = 1'b0;
    endtask

    task automatic clear_err();
        acc_err_clr = 1'b1;
        @(negedge clk);
        acc_err_clr = 1'b0;
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (!cmd_done);
    endtask

    task automatic prot_write(input logic [PROT_W-1:0] v);
        prot_data = v;
        prot_wr = 1'b1;
        @(negedge clk);
        prot_wr = 1'b0;
    endtask

    // Monitor: measures each cmd_done low window and compares with the scoreboard
    always @(negedge clk) begin
        if (!rst) begin
            if (!cmd_done) begin
                low_cnt++;
            end else if (low_cnt > 0) begin
                if (exp_dur.size() == 0) begin
                    chk("R2 unexpected completion", low_cnt, 0);
                end else begin
                    int d;
                    bit e;
                    d = exp_dur.pop_front();
                    e = exp_err.pop_front();
                    if (d > 0) chk("R2 done window", low_cnt, d);
                    chk("R2 acc_err at completion", int'(acc_err), int'(e));
                end
                low_cnt = 0;
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R13 reset state
        chk("R13 buf_empty", int'(buf_empty), 1);
        chk("R13 cmd_done", int'(cmd_done), 1);
        chk("R13 acc_err", int'(acc_err), 0);
        chk("R13 pump_en", int'(pump_en), 0);
        chk("R13 prot_q", int'(prot_q), 0);

        // R1, R3: program with latency 3
        lat = 8'd3;
        expect_done(5, 0);
        issue(3'd1);
        chk("R1 buf_empty after write", int'(buf_empty), 0);
        chk("R1 cmd_done after write", int'(cmd_done), 0);
        repeat (2) @(negedge clk);
        chk("R3 pump during program", int'(pump_en), 1);
        wait_idle();

        // R3: verify does not use the pump
        expect_done(5, 0);
        issue(3'd0);
        repeat (2) @(negedge clk);
        chk("R3 pump during verify", int'(pump_en), 0);
        wait_idle();

        // R4: wait request with a running and a waiting command
        wait_req = 1'b1;
        lat = 8'd4;
        expect_done(12, 0);
        issue(3'd2);
        @(negedge clk);
        issue(3'd4);
        chk("R4 second command held", int'(buf_empty), 0);
        wait_idle();

        // R5: wake and interrupt
        ie_cmd_done = 1'b1;
        #1;
        chk("R5 wake with done enable", int'(wake_req), 1);
        ie_cmd_done = 1'b0;
        #1;
        chk("R5 no wake without enables", int'(wake_req), 0);
        chk("R5 no irq without enables", int'(irq), 0);
        wait_req = 1'b0;
        ie_buf_empty = 1'b1;
        #1;
        chk("R5 irq from slot empty", int'(irq), 1);
        chk("R5 no wake outside wait", int'(wake_req), 0);
        ie_buf_empty = 1'b0;
        @(negedge clk);

        // R6, R7, R8: stop during program with a waiting command
        lat = 8'd20;
        expect_done(0, 1);
        issue(3'd1);
        @(negedge clk);
        issue(3'd2);
        chk("R3 pump before stop", int'(pump_en), 1);
        repeat (2) @(negedge clk);
        stop_req = 1'b1;
        #1;
        chk("R7 pump cut with stop", int'(pump_en), 0);
        @(negedge clk);
        chk("R6 acc_err after abort", int'(acc_err), 1);
        chk("R6 cmd_done after abort", int'(cmd_done), 1);
        repeat (2) @(negedge clk);
        stop_req = 1'b0;
        @(negedge clk);
        chk("R8 slot empty after stop exit", int'(buf_empty), 1);
        repeat (6) @(negedge clk);
        chk("R8 waiting command not started", int'(cmd_done), 1);
        chk("R8 pump stays off", int'(pump_en), 0);

        // R9: refused while error set, then cleared
        issue(3'd1);
        chk("R9 refused write slot", int'(buf_empty), 1);
        chk("R9 refused write done", int'(cmd_done), 1);
        clear_err();
        chk("R9 error cleared", int'(acc_err), 0);
        lat = 8'd2;
        expect_done(4, 0);
        issue(3'd3);
        wait_idle();

        // R10: illegal opcode and write into an occupied slot
        issue(3'd6);
        chk("R10 illegal opcode error", int'(acc_err), 1);
        chk("R10 illegal opcode slot", int'(buf_empty), 1);
        clear_err();
        lat = 8'd10;
        expect_done(24, 1);
        issue(3'd1);
        @(negedge clk);
        issue(3'd0);
        issue(3'd1);
        chk("R10 write into full slot", int'(acc_err), 1);
        wait_idle();
        clear_err();

        // R11: secured special single-chip allows only mass erase
        sec_on = 1'b1;
        spec_single = 1'b1;
        dbg_mode = 1'b1;
        issue(3'd1);
        chk("R11 program refused", int'(acc_err), 1);
        chk("R11 program slot", int'(buf_empty), 1);
        clear_err();
        lat = 8'd3;
        expect_done(5, 0);
        issue(3'd3);
        chk("R11 mass erase accepted", int'(acc_err), 0);
        wait_idle();
        sec_on = 1'b0;
        expect_done(5, 0);
        issue(3'd4);
        chk("R11 unsecured accepts modify", int'(acc_err), 0);
        wait_idle();
        spec_single = 1'b0;
        dbg_mode = 1'b0;

        // R12: protection register
        prot_write(8'h5A);
        chk("R12 first write", int'(prot_q), 'h5A);
        prot_write(8'h33);
        chk("R12 second write ignored", int'(prot_q), 'h5A);
        dbg_mode = 1'b1;
        prot_write(8'h33);
        chk("R12 debug write", int'(prot_q), 'h33);
        dbg_mode = 1'b0;
        prot_write(8'h77);
        chk("R12 locked after debug", int'(prot_q), 'h33);

        repeat (3) @(negedge clk);
        chk("R2 all completions seen", exp_dur.size(), 0);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule